// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Serial Word Receiver

This block recovers 32-bit words from a two-wire return-to-zero serial line. A high level on the "one" wire carries a 1 and a high level on the "zero" wire carries a 0. When both wires are low the line is in its null state, and a long null run marks the gap between words. The line is sampled with a clock that runs at four times the nominal bit rate. Each pulse is qualified by its length before it counts as a bit. Bits arrive least significant first, and the first byte of a word is its label.

Once eight bits have arrived, the receiver presents the label to an external label filter and samples the filter's verdict. A rejected word is dropped without any trace. An accepted word is checked for odd parity and exact length. The word is then handed to the host in one of two ways: as four separate bytes, with a flag that marks the first byte, or as one complete word. Status outputs report data ready, overwrite of unread data, parity failure and framing failure. A one-shot hold bit keeps the ready output low for the duration of one word and clears itself when that word ends.

Top module: `rz_word_rx`

## Requirements
- R1: After reset, rx_data is zero and rx_ready, first_flag, overrun_err, parity_err, framing_err and hold_armed are all low.
- R2: After reset, and after the receiver is disabled or a bit is invalid, no bit is taken into a word until a gap of at least GAP_NULL (default 12) consecutive null samples has been seen. A word that starts earlier is ignored and sets no output.
- R3: A pulse counts as a valid bit when exactly one wire is high for at least MIN_HIGH (default 2) consecutive samples and the line then returns to null. A high on line_one is 1 and a high on line_zero is 0. The first bit received goes to rx_data bit 0 and the last to bit 31.
- R4: In word mode (mode_word=1), after the 32nd bit of a word with an odd count of ones, rx_data holds the word and rx_ready and first_flag go high.
- R5: A 32-bit word with an even count of ones sets parity_err. It raises neither rx_ready nor first_flag and leaves rx_data unchanged.
- R6: framing_err is set in any of these cases: a gap arrives after 1 to 31 bits; a 33rd bit follows a complete word; a pulse holds both wires high; a pulse is shorter than MIN_HIGH samples.
- R7: In byte mode (mode_word=0), each completed byte k (bits 8k to 8k+7) is placed in rx_data[7:0] with rx_data[31:8] zero, and rx_ready goes high. first_flag is high for byte 0 only. Byte 3 is delivered only if the word parity is odd.
- R8: A one-cycle pulse on hold_set raises hold_armed. While hold_armed is high, deliveries update rx_data and first_flag but do not raise rx_ready. hold_armed clears when the word being received ends (delivered, discarded or aborted).
- R9: A delivery that arrives while rx_ready is still high and data_read is low sets overrun_err, and rx_data takes the new value.
- R10: A one-cycle data_read pulse clears rx_ready, first_flag, overrun_err, parity_err and framing_err.
- R11: One cycle after the eighth bit, label_strobe pulses with label_out equal to the first eight bits received. If label_hit is low in that cycle, the word is discarded: no output changes, and the remaining bits are ignored until a gap.
- R12: While rx_en is low, no word is accepted and any partial word is dropped without a flag. Bits that arrive after re-enable and before the next gap are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| line_one | input | 1 | Serial wire that goes high for a 1 bit |
| line_zero | input | 1 | Serial wire that goes high for a 0 bit |
| rx_en | input | 1 | Receiver enable |
| mode_word | input | 1 | 1: deliver whole 32-bit words, 0: deliver bytes |
| hold_set | input | 1 | Pulse arms the one-word ready hold |
| data_read | input | 1 | Pulse acknowledges data and clears status |
| label_hit | input | 1 | Filter verdict, sampled while label_strobe is high |
| label_strobe | output | 1 | Label is presented to the filter |
| label_out | output | 8 | First eight bits of the current word |
| rx_data | output | 32 | Received word, or byte in bits 7:0 |
| rx_ready | output | 1 | Unread data available |
| first_flag | output | 1 | First byte (byte mode) or valid word (word mode) |
| parity_err | output | 1 | Word had even parity |
| framing_err | output | 1 | Word did not hold exactly 32 valid bits |
| overrun_err | output | 1 | Unread data was overwritten |
| hold_armed | output | 1 | One-word ready hold is pending |

## Verification
A pulse's fall passes two synchronizer flops, the bit strobe register, the word builder and the status register. Each delivered result therefore shows up after the fifth rising edge that follows the falling-edge change of the wires. All stimulus is driven on falling edges, and every output is sampled on a falling edge. In byte mode a check is made at least six cycles after the last bit of a byte drops, which stays well under the twelve-sample gap threshold, so the word continues afterwards. Word-level results are checked after sixteen null cycles, once the gap has been declared and every register stage has settled.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;

    typedef enum logic [2:0] {
        ST_WAITGAP,
        ST_IDLE,
        ST_RECV,
        ST_TAIL,
        ST_DROP
    } asm_state_e;

    typedef struct packed {
        logic stb;
        logic ok;
        logic val;
    } bit_evt_t;

endpackage

// File: rtl/rzrx_bit_slicer.sv
module rzrx_bit_slicer
    import rzrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int GAP_NULL    = 12,
    parameter int CNTW        = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_one,
    input  logic     line_zero,
    output bit_evt_t evt,
    output logic     gap
);
    localparam int NW = $clog2(GAP_NULL + 1);
    localparam logic [CNTW-1:0] HMAX = '1;
    localparam logic [CNTW-1:0] MINH = CNTW'(MIN_HIGH);
    localparam logic [NW-1:0]   GAPV = NW'(GAP_NULL);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sy1;
        logic [SYNC_STAGES-1:0] sy0;
        logic [CNTW-1:0]        n1;
        logic [CNTW-1:0]        n0;
        logic                   both;
        logic                   busy;
        logic [NW-1:0]          nul;
        logic                   stb;
        logic                   ok;
        logic                   val;
    } slicer_t;

    slicer_t q, d;
    logic r1, r0;

    assign r1 = q.sy1[SYNC_STAGES-1];
    assign r0 = q.sy0[SYNC_STAGES-1];

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        d.ok  = 1'b0;
        d.val = 1'b0;
        d.sy1 = {q.sy1[SYNC_STAGES-2:0], line_one};
        d.sy0 = {q.sy0[SYNC_STAGES-2:0], line_zero};
        if (r1 || r0) begin
            d.busy = 1'b1;
            d.nul  = '0;
            if (r1 && r0) d.both = 1'b1;
            if (r1 && q.n1 != HMAX) d.n1 = q.n1 + 1'b1;
            if (r0 && q.n0 != HMAX) d.n0 = q.n0 + 1'b1;
        end else begin
            if (q.nul != GAPV) d.nul = q.nul + 1'b1;
            if (q.busy) begin
                d.stb  = 1'b1;
                d.val  = (q.n1 != '0);
                d.ok   = !q.both &&
                         ((q.n1 >= MINH && q.n0 == '0) ||
                          (q.n0 >= MINH && q.n1 == '0));
                d.busy = 1'b0;
                d.both = 1'b0;
                d.n1   = '0;
                d.n0   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt.stb = q.stb;
    assign evt.ok  = q.ok;
    assign evt.val = q.val;
    assign gap     = (q.nul == GAPV);

endmodule

// File: rtl/rzrx_word_builder.sv
module rzrx_word_builder
    import rzrx_pkg::*;
#(
    parameter int WORD_BITS = 32,
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  logic                 mode_word,
    input  bit_evt_t             evt,
    input  logic                 gap,
    input  logic                 label_hit,
    output logic                 label_strobe,
    output logic [BYTE_BITS-1:0] label_out,
    output logic                 pub_valid,
    output logic [WORD_BITS-1:0] pub_data,
    output logic                 pub_first,
    output logic                 err_parity,
    output logic                 err_frame,
    output logic                 word_end
);
    localparam int CW = $clog2(WORD_BITS + 1);
    localparam int IW = $clog2(WORD_BITS);
    localparam logic [CW-1:0] FULL  = CW'(WORD_BITS);
    localparam logic [CW-1:0] BYTEC = CW'(BYTE_BITS);

    typedef struct packed {
        asm_state_e           st;
        logic [CW-1:0]        cnt;
        logic [WORD_BITS-1:0] shreg;
        logic                 pend;
    } build_t;

    build_t q, d;
    logic                 parity_ok;
    logic [WORD_BITS-1:0] shifted;
    logic [CW-1:0]        cnt_nx;

    assign parity_ok    = ^q.shreg;
    assign shifted      = q.shreg >> (q.cnt - BYTEC);
    assign cnt_nx       = q.cnt + 1'b1;
    assign label_out    = q.shreg[BYTE_BITS-1:0];
    assign label_strobe = rx_en && q.pend && (q.cnt == BYTEC);

    always_comb begin
        d          = q;
        pub_valid  = 1'b0;
        pub_data   = '0;
        pub_first  = 1'b0;
        err_parity = 1'b0;
        err_frame  = 1'b0;
        word_end   = 1'b0;

        if (!rx_en) begin
            if (q.st == ST_RECV) word_end = 1'b1;
            d.st   = ST_WAITGAP;
            d.cnt  = '0;
            d.pend = 1'b0;
        end else if (q.pend) begin
            d.pend = 1'b0;
            if (q.cnt == BYTEC && !label_hit) begin
                d.st     = ST_DROP;
                word_end = 1'b1;
            end else begin
                if (q.cnt == FULL) begin
                    word_end = 1'b1;
                    d.st     = ST_TAIL;
                    if (!parity_ok) err_parity = 1'b1;
                end
                if (!mode_word) begin
                    if (q.cnt != FULL || parity_ok) begin
                        pub_valid = 1'b1;
                        pub_data  = {{(WORD_BITS-BYTE_BITS){1'b0}},
                                     shifted[BYTE_BITS-1:0]};
                        pub_first = (q.cnt == BYTEC);
                    end
                end else if (q.cnt == FULL && parity_ok) begin
                    pub_valid = 1'b1;
                    pub_data  = q.shreg;
                    pub_first = 1'b1;
                end
            end
        end else if (evt.stb) begin
            case (q.st)
                ST_IDLE: begin
                    if (evt.ok) begin
                        d.shreg = {{(WORD_BITS-1){1'b0}}, evt.val};
                        d.cnt   = CW'(1);
                        d.st    = ST_RECV;
                    end else begin
                        err_frame = 1'b1;
                        d.st      = ST_WAITGAP;
                    end
                end
                ST_RECV: begin
                    if (evt.ok) begin
                        d.shreg[q.cnt[IW-1:0]] = evt.val;
                        d.cnt  = cnt_nx;
                        d.pend = ((cnt_nx % BYTEC) == '0);
                    end else begin
                        err_frame = 1'b1;
                        word_end  = 1'b1;
                        d.st      = ST_WAITGAP;
                    end
                end
                ST_TAIL: begin
                    err_frame = 1'b1;
                    d.st      = ST_WAITGAP;
                end
                default: ;
            endcase
        end else if (gap) begin
            case (q.st)
                ST_WAITGAP, ST_DROP, ST_TAIL: d.st = ST_IDLE;
                ST_RECV: begin
                    err_frame = 1'b1;
                    word_end  = 1'b1;
                    d.st      = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_WAITGAP;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/rzrx_status.sv
module rzrx_status #(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 data_read,
    input  logic                 hold_set,
    input  logic                 pub_valid,
    input  logic [WORD_BITS-1:0] pub_data,
    input  logic                 pub_first,
    input  logic                 err_parity,
    input  logic                 err_frame,
    input  logic                 word_end,
    output logic [WORD_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 first_flag,
    output logic                 overrun_err,
    output logic                 parity_err,
    output logic                 framing_err,
    output logic                 hold_armed
);
    typedef struct packed {
        logic [WORD_BITS-1:0] data;
        logic                 ready;
        logic                 first;
        logic                 ovr;
        logic                 par;
        logic                 frm;
        logic                 hold;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        if (data_read) begin
            d.ready = 1'b0;
            d.first = 1'b0;
            d.ovr   = 1'b0;
            d.par   = 1'b0;
            d.frm   = 1'b0;
        end
        if (pub_valid) begin
            d.data  = pub_data;
            d.first = pub_first;
            if (q.ready && !data_read) d.ovr = 1'b1;
            if (!q.hold) d.ready = 1'b1;
        end
        if (err_parity) d.par = 1'b1;
        if (err_frame)  d.frm = 1'b1;
        if (word_end)   d.hold = 1'b0;
        if (hold_set)   d.hold = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data     = q.data;
    assign rx_ready    = q.ready;
    assign first_flag  = q.first;
    assign overrun_err = q.ovr;
    assign parity_err  = q.par;
    assign framing_err = q.frm;
    assign hold_armed  = q.hold;

endmodule

// File: rtl/rz_word_rx.sv
module rz_word_rx
    import rzrx_pkg::*;
#(
    parameter int WORD_BITS   = 32,
    parameter int BYTE_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int GAP_NULL    = 12,
    parameter int CNTW        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_one,
    input  logic                 line_zero,
    input  logic                 rx_en,
    input  logic                 mode_word,
    input  logic                 hold_set,
    input  logic                 data_read,
    input  logic                 label_hit,
    output logic                 label_strobe,
    output logic [BYTE_BITS-1:0] label_out,
    output logic [WORD_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 first_flag,
    output logic                 parity_err,
    output logic                 framing_err,
    output logic                 overrun_err,
    output logic                 hold_armed
);
    bit_evt_t             evt;
    logic                 gap;
    logic                 pub_valid;
    logic [WORD_BITS-1:0] pub_data;
    logic                 pub_first;
    logic                 err_parity;
    logic                 err_frame;
    logic                 word_end;

    rzrx_bit_slicer #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_HIGH   (MIN_HIGH),
        .GAP_NULL   (GAP_NULL),
        .CNTW       (CNTW)
    ) u_slicer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_one (line_one),
        .line_zero(line_zero),
        .evt      (evt),
        .gap      (gap)
    );

    rzrx_word_builder #(
        .WORD_BITS(WORD_BITS),
        .BYTE_BITS(BYTE_BITS)
    ) u_builder (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .mode_word   (mode_word),
        .evt         (evt),
        .gap         (gap),
        .label_hit   (label_hit),
        .label_strobe(label_strobe),
        .label_out   (label_out),
        .pub_valid   (pub_valid),
        .pub_data    (pub_data),
        .pub_first   (pub_first),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .word_end    (word_end)
    );

    rzrx_status #(
        .WORD_BITS(WORD_BITS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_read  (data_read),
        .hold_set   (hold_set),
        .pub_valid  (pub_valid),
        .pub_data   (pub_data),
        .pub_first  (pub_first),
        .err_parity (err_parity),
        .err_frame  (err_frame),
        .word_end   (word_end),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .first_flag (first_flag),
        .overrun_err(overrun_err),
        .parity_err (parity_err),
        .framing_err(framing_err),
        .hold_armed (hold_armed)
    );

endmodule

// File: rtl/rz_word_rx_chk.sv
module rz_word_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_en,
    input logic hold_set,
    input logic data_read,
    input logic label_hit,
    input logic label_strobe,
    input logic rx_ready,
    input logic first_flag,
    input logic parity_err,
    input logic framing_err,
    input logic overrun_err,
    input logic hold_armed,
    input logic pub_valid,
    input logic err_parity,
    input logic err_frame,
    input logic word_end
);
    // R4: ready only rises from an unheld delivery
    p_ready_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(pub_valid && !hold_armed));

    // R8: an armed hold keeps a low ready low
    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_armed && !rx_ready |=> !rx_ready);

    // R8: hold clears when a word ends
    p_hold_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_end && !hold_set |=> !hold_armed);

    // R9: overrun only when a delivery meets unread data
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(pub_valid && rx_ready));

    // R10: a read with nothing new clears every status flag
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        data_read && !pub_valid && !err_parity && !err_frame |=>
        !rx_ready && !first_flag && !overrun_err && !parity_err && !framing_err);

    // R11: a rejected label never leads to a delivery
    p_label_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        label_strobe && !label_hit |-> !pub_valid);

    // R12: nothing is delivered while disabled
    p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> !pub_valid && !label_strobe);

endmodule

bind rz_word_rx rz_word_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .hold_set    (hold_set),
    .data_read   (data_read),
    .label_hit   (label_hit),
    .label_strobe(label_strobe),
    .rx_ready    (rx_ready),
    .first_flag  (first_flag),
    .parity_err  (parity_err),
    .framing_err (framing_err),
    .overrun_err (overrun_err),
    .hold_armed  (hold_armed),
    .pub_valid   (pub_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .word_end    (word_end)
);

// File: tb/rz_word_rx_test.sv
`timescale 1ns/1ps
module rz_word_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_one = 1'b0, line_zero = 1'b0;
    logic        rx_en = 1'b1, mode_word = 1'b1;
    logic        hold_set = 1'b0, data_read = 1'b0;
    logic        label_hit;
    logic        label_strobe;
    logic [7:0]  label_out;
    logic [31:0] rx_data;
    logic        rx_ready, first_flag, parity_err, framing_err, overrun_err, hold_armed;

    logic        filt_on = 1'b0;
    logic [7:0]  filt_lbl = 8'h00;
    logic [7:0]  seen_lbl = 8'h00;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    assign label_hit = !filt_on || (label_out == filt_lbl);

    always @(posedge clk) if (label_strobe) seen_lbl <= label_out;

    rz_word_rx uut (
        .clk(clk), .rst_n(rst_n), .line_one(line_one), .line_zero(line_zero),
        .rx_en(rx_en), .mode_word(mode_word), .hold_set(hold_set),
        .data_read(data_read), .label_hit(label_hit),
        .label_strobe(label_strobe), .label_out(label_out), .rx_data(rx_data),
        .rx_ready(rx_ready), .first_flag(first_flag), .parity_err(parity_err),
        .framing_err(framing_err), .overrun_err(overrun_err),
        .hold_armed(hold_armed)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] odd_word(input logic [30:0] x);
        return {~^x, x};
    endfunction

    function automatic logic [31:0] even_word(input logic [30:0] x);
        return {^x, x};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_raw(input logic o, input logic z, input int hi);
        @(negedge clk);
        line_one  = o;
        line_zero = z;
        repeat (hi) @(negedge clk);
        line_one  = 1'b0;
        line_zero = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        send_raw(v, ~v, 2);
    endtask

    task automatic send_bits(input logic [31:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) send_bit(w[i]);
    endtask

    task automatic do_read();
        @(negedge clk) data_read = 1'b1;
        @(negedge clk) data_read = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rx_data",  rx_data, 32'h0);
        check("R1 flags", {26'h0, rx_ready, first_flag, parity_err, framing_err, overrun_err, hold_armed}, 32'h0);
    endtask

    task automatic t_no_gap_after_reset();
        send_bits(odd_word(31'h0ABC_1234), 0, 31);
        idle(16);
        check("R2 ready", {31'h0, rx_ready}, 32'h0);
        check("R2 data",  rx_data, 32'h0);
        check("R2 framing", {31'h0, framing_err}, 32'h0);
    endtask

    task automatic t_word_basic();
        logic [31:0] w = odd_word(31'h3456_78A5);
        send_bits(w, 0, 31);
        idle(16);
        check("R4 ready", {31'h0, rx_ready}, 32'h1);
        check("R3 data order", rx_data, w);
        check("R4 first", {31'h0, first_flag}, 32'h1);
        check("R11 label", {24'h0, seen_lbl}, {24'h0, w[7:0]});
        do_read();
        @(negedge clk);
        check("R10 read clears", {30'h0, rx_ready, first_flag}, 32'h0);
    endtask

    task automatic t_parity();
        logic [31:0] old = rx_data;
        send_bits(even_word(31'h1111_2222), 0, 31);
        idle(16);
        check("R5 parity_err", {31'h0, parity_err}, 32'h1);
        check("R5 no ready", {30'h0, rx_ready, first_flag}, 32'h0);
        check("R5 data kept", rx_data, old);
        do_read();
        @(negedge clk);
        check("R10 parity cleared", {31'h0, parity_err}, 32'h0);
    endtask

    task automatic t_framing();
        logic [31:0] w = odd_word(31'h0F0F_1234);
        send_bits(w, 0, 19);
        idle(16);
        check("R6 short word", {30'h0, framing_err, rx_ready}, 32'h2);
        do_read();
        send_bits(w, 0, 2);
        send_raw(1'b1, 1'b1, 2);
        idle(16);
        check("R6 both rails", {30'h0, framing_err, rx_ready}, 32'h2);
        do_read();
        send_raw(1'b1, 1'b0, 1);
        idle(16);
        check("R3 short pulse", {30'h0, framing_err, rx_ready}, 32'h2);
        do_read();
        send_bits(w, 0, 31);
        send_bit(1'b1);
        idle(16);
        check("R6 extra bit", {30'h0, framing_err, rx_ready}, 32'h3);
        check("R6 extra bit data", rx_data, w);
        do_read();
        idle(4);
    endtask

    task automatic t_byte_mode();
        logic [31:0] w = odd_word(31'h2C3B_4A59);
        mode_word = 1'b0;
        for (int k = 0; k < 4; k++) begin
            send_bits(w, 8 * k, 8 * k + 7);
            idle(5);
            check("R7 byte ready", {31'h0, rx_ready}, 32'h1);
            check("R7 byte data", rx_data, {24'h0, w[8*k +: 8]});
            check("R7 first flag", {31'h0, first_flag}, (k == 0) ? 32'h1 : 32'h0);
            do_read();
            check("R10 byte read", {31'h0, rx_ready}, 32'h0);
        end
        idle(16);
        check("R7 no errors", {29'h0, parity_err, framing_err, overrun_err}, 32'h0);
        mode_word = 1'b1;
    endtask

    task automatic t_overrun();
        logic [31:0] w1 = odd_word(31'h0000_1357);
        logic [31:0] w2 = odd_word(31'h7654_0246);
        send_bits(w1, 0, 31);
        idle(16);
        send_bits(w2, 0, 31);
        idle(16);
        check("R9 overrun", {30'h0, overrun_err, rx_ready}, 32'h3);
        check("R9 new data", rx_data, w2);
        do_read();
        @(negedge clk);
        check("R10 overrun cleared", {31'h0, overrun_err}, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] w1 = odd_word(31'h5A5A_0011);
        logic [31:0] w2 = odd_word(31'h1234_0022);
        @(negedge clk) hold_set = 1'b1;
        @(negedge clk) hold_set = 1'b0;
        check("R8 armed", {31'h0, hold_armed}, 32'h1);
        send_bits(w1, 0, 31);
        idle(16);
        check("R8 ready held", {31'h0, rx_ready}, 32'h0);
        check("R8 data updated", rx_data, w1);
        check("R8 first kept", {31'h0, first_flag}, 32'h1);
        check("R8 self clear", {31'h0, hold_armed}, 32'h0);
        do_read();
        send_bits(w2, 0, 31);
        idle(16);
        check("R8 next word ready", {31'h0, rx_ready}, 32'h1);
        do_read();
    endtask

    task automatic t_label();
        logic [31:0] old = rx_data;
        logic [31:0] bad = odd_word({23'h12AB3, 8'h33});
        logic [31:0] good = odd_word({23'h0ACE5, 8'h5A});
        filt_on  = 1'b1;
        filt_lbl = 8'h5A;
        send_bits(bad, 0, 31);
        idle(16);
        check("R11 strobe label", {24'h0, seen_lbl}, 32'h33);
        check("R11 dropped", {27'h0, rx_ready, first_flag, parity_err, framing_err, overrun_err}, 32'h0);
        check("R11 data kept", rx_data, old);
        send_bits(good, 0, 31);
        idle(16);
        check("R11 match ready", {31'h0, rx_ready}, 32'h1);
        check("R11 match data", rx_data, good);
        do_read();
        filt_on = 1'b0;
    endtask

    task automatic t_disable();
        logic [31:0] old = rx_data;
        logic [31:0] w = odd_word(31'h6161_0707);
        send_bits(w, 0, 15);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        send_bits(w, 16, 31);
        idle(16);
        check("R12 partial dropped", {29'h0, rx_ready, framing_err, parity_err}, 32'h0);
        check("R12 data kept", rx_data, old);
        rx_en = 1'b0;
        send_bits(w, 0, 31);
        idle(16);
        check("R12 disabled word", {31'h0, rx_ready}, 32'h0);
        rx_en = 1'b1;
        idle(4);
        send_bits(w, 0, 31);
        idle(16);
        check("R12 re-enabled word", {31'h0, rx_ready}, 32'h1);
        check("R12 re-enabled data", rx_data, w);
        do_read();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_no_gap_after_reset();
        t_word_basic();
        t_parity();
        t_framing();
        t_byte_mode();
        t_overrun();
        t_hold();
        t_label();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule